// File: doc/BRIEF.md
# Exception Source Detection Classifier

This block sits beside the decode stage of a simple in-order CPU and decides which exception source is active and in which cycle its processing may begin. It watches two active-low reset pins, a watchdog overflow pulse, an address-error flag, an interrupt request and a set of decode-stage flags. The decode flags say whether the decoded opcode is valid, whether it is undefined, whether it sits in a delay slot, whether it rewrites the PC, and whether a trap is executing. A further flag says whether the previous instruction has completed.

When a source is active, the block issues a one-cycle start request with a 3-bit exception type. Codes: 0 power-on reset, 1 manual reset, 2 address error, 3 illegal slot instruction, 4 general illegal instruction, 5 trap, 6 interrupt. Type 7 is never produced. An undefined opcode counts as a general illegal instruction unless it sits in a delay slot. An undefined opcode in a delay slot, or any PC-rewriting instruction in a delay slot, counts as an illegal slot instruction. PC-rewriting instructions are jumps, calls, branches, returns, conditional branches and the trap. An address error is recorded at decode but is held until the previous instruction has completed.

Top module: `exc_src_detect`

## Requirements
- R1: A low-to-high transition of `por_pin_ni` gives `start_o`=1 with `type_o`=0. It appears on the third rising clock edge after the pin changes, because of two synchroniser flops and one output register. A `wdt_ovf_i` pulse gives the same start on the next edge.
- R2: A low-to-high transition of `mrst_pin_ni` gives `start_o`=1 with `type_o`=1 on the third rising clock edge after the pin changes.
- R3: `addr_err_i` with `dec_valid_i` is recorded as pending. A pending address error gives `start_o`=1 with `type_o`=2 on the edge that follows a cycle in which `prev_done_i`=1. The pending error is held for as long as `prev_done_i` stays 0, and `prev_done_i` in the same cycle as the detection does not start it.
- R4: `dec_valid_i` with `dec_undef_i` and `dec_dslot_i` gives `type_o`=3 on the next edge.
- R5: `dec_valid_i` with `dec_pcw_i` and `dec_dslot_i` gives `type_o`=3 on the next edge. A PC-rewriting instruction outside a delay slot gives no start.
- R6: `dec_valid_i` with `dec_undef_i` and without `dec_dslot_i` gives `type_o`=4 on the next edge. All decode flags are ignored while `dec_valid_i`=0.
- R7: `trap_exec_i` gives `type_o`=5 on the next edge.
- R8: `irq_req_i` gives `type_o`=6 on the next edge.
- R9: When several sources are active in one cycle, the lowest type code wins, and the losing sources are dropped. The one exception is a pending address error that loses to a non-reset source: it stays pending. A reset start, from either pin or from the watchdog, clears any pending address error.
- R10: `start_o` is high for exactly one cycle per event. While `start_o`=0, `type_o` reads 0.
- R11: After `rst_ni` is released, reset pins that are held low or held high give no start. Only the rising transition counts. In reset, `start_o`=0 and `type_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_pin_ni | input | 1 | Primary reset pin, active low, asynchronous |
| mrst_pin_ni | input | 1 | Manual reset pin, active low, asynchronous |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| addr_err_i | input | 1 | Address error seen for the decoded instruction |
| dec_valid_i | input | 1 | Decode stage holds a valid opcode |
| dec_undef_i | input | 1 | Decoded opcode is undefined |
| dec_dslot_i | input | 1 | Decoded opcode sits in a delay slot |
| dec_pcw_i | input | 1 | Decoded opcode rewrites the PC |
| trap_exec_i | input | 1 | Trap instruction executes this cycle |
| prev_done_i | input | 1 | Previous instruction has completed |
| irq_req_i | input | 1 | Accepted interrupt request |
| start_o | output | 1 | One-cycle exception start request |
| type_o | output | 3 | Exception type code |

## Verification
A fault in the edge detector shows up on a reset pin in one of three ways. The start arrives before or after the third edge, it repeats while the pin stays high, or it appears on the falling edge. A pending flag that leaks is seen within two cycles: either type 2 appears without a completion cycle before it, or it appears again after a reset start. A misclassified decode context shows up on the very next edge as type 3 and type 4 swapped, or as a start for an in-slot-free branch. A wrong priority shows up as the wrong code on that edge, or as a held-back address error that never starts.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned TYPE_W  = 3;
  localparam int unsigned NUM_SRC = 7;

  typedef enum logic [TYPE_W-1:0] {
    EXC_POR  = 3'd0,
    EXC_MRST = 3'd1,
    EXC_ADDR = 3'd2,
    EXC_SLOT = 3'd3,
    EXC_ILLG = 3'd4,
    EXC_TRAP = 3'd5,
    EXC_IRQ  = 3'd6
  } exc_type_e;
endpackage

// File: rtl/exc_pin_edge.sv
module exc_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= pin_ni;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  // idle level is high; reset to high so release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/exc_dec_class.sv
module exc_dec_class (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dec_valid_i,
  input  logic dec_undef_i,
  input  logic dec_dslot_i,
  input  logic dec_pcw_i,
  input  logic addr_err_i,
  input  logic prev_done_i,
  input  logic flush_i,
  output logic slot_req_o,
  output logic illg_req_o,
  output logic ae_fire_o
);
  logic ae_pend_q;
  logic ae_set;

  assign slot_req_o = dec_valid_i & dec_dslot_i & (dec_undef_i | dec_pcw_i);
  assign illg_req_o = dec_valid_i & dec_undef_i & ~dec_dslot_i;
  assign ae_set     = dec_valid_i & addr_err_i;
  assign ae_fire_o  = ae_pend_q & prev_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ae_pend_q <= 1'b0;
    else if (flush_i || ae_fire_o)  ae_pend_q <= 1'b0;
    else if (ae_set)                ae_pend_q <= 1'b1;
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  output logic              start_o,
  output logic [TYPE_W-1:0] type_o
);
  logic [TYPE_W-1:0] win;

  // lowest index = highest priority
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) win = TYPE_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      type_o  <= '0;
    end else begin
      start_o <= |req_i;
      type_o  <= (|req_i) ? win : '0;
    end
  end
endmodule

// File: rtl/exc_src_detect.sv
module exc_src_detect
  import exc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_pin_ni,
  input  logic              mrst_pin_ni,
  input  logic              wdt_ovf_i,
  input  logic              addr_err_i,
  input  logic              dec_valid_i,
  input  logic              dec_undef_i,
  input  logic              dec_dslot_i,
  input  logic              dec_pcw_i,
  input  logic              trap_exec_i,
  input  logic              prev_done_i,
  input  logic              irq_req_i,
  output logic              start_o,
  output logic [TYPE_W-1:0] type_o
);
  localparam int unsigned NPIN = 2;

  logic [NPIN-1:0]    pins_n;
  logic [NPIN-1:0]    pin_rise;
  logic               por_rise, mr_rise, por_evt, rst_evt;
  logic               slot_req, illg_req, ae_fire;
  logic [NUM_SRC-1:0] req;

  assign pins_n = {mrst_pin_ni, por_pin_ni};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    exc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (pins_n[p]),
      .rise_o (pin_rise[p])
    );
  end

  assign por_rise = pin_rise[0];
  assign mr_rise  = pin_rise[1];
  assign por_evt  = por_rise | wdt_ovf_i;
  assign rst_evt  = por_evt | mr_rise;

  exc_dec_class u_class (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_valid_i (dec_valid_i),
    .dec_undef_i (dec_undef_i),
    .dec_dslot_i (dec_dslot_i),
    .dec_pcw_i   (dec_pcw_i),
    .addr_err_i  (addr_err_i),
    .prev_done_i (prev_done_i),
    .flush_i     (rst_evt),
    .slot_req_o  (slot_req),
    .illg_req_o  (illg_req),
    .ae_fire_o   (ae_fire)
  );

  always_comb begin
    req           = '0;
    req[EXC_POR]  = por_evt;
    req[EXC_MRST] = mr_rise;
    req[EXC_ADDR] = ae_fire;
    req[EXC_SLOT] = slot_req;
    req[EXC_ILLG] = illg_req;
    req[EXC_TRAP] = trap_exec_i;
    req[EXC_IRQ]  = irq_req_i;
  end

  exc_arbiter #(.N(NUM_SRC)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .start_o (start_o),
    .type_o  (type_o)
  );
endmodule

// File: rtl/exc_src_detect_chk.sv
module exc_src_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wdt_ovf_i,
  input logic       dec_valid_i,
  input logic       dec_undef_i,
  input logic       dec_dslot_i,
  input logic       dec_pcw_i,
  input logic       prev_done_i,
  input logic       por_rise,
  input logic       mr_rise,
  input logic       ae_fire,
  input logic       start_o,
  input logic [2:0] type_o
);
  logic hi_quiet;
  assign hi_quiet = !wdt_ovf_i && !por_rise && !mr_rise && !ae_fire;

  p_type_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> type_o != 3'd7);

  p_idle_type_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> type_o == 3'd0);

  p_wdt_por_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_ovf_i |=> start_o && type_o == 3'd0);

  p_mrst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_rise && !por_rise && !wdt_ovf_i) |=> start_o && type_o == 3'd1);

  p_ae_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && type_o == 3'd2) |-> $past(prev_done_i));

  p_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_quiet && dec_valid_i && dec_dslot_i && (dec_undef_i || dec_pcw_i))
      |=> start_o && type_o == 3'd3);

  p_illg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_quiet && dec_valid_i && dec_undef_i && !dec_dslot_i)
      |=> start_o && type_o == 3'd4);
endmodule

bind exc_src_detect exc_src_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wdt_ovf_i   (wdt_ovf_i),
  .dec_valid_i (dec_valid_i),
  .dec_undef_i (dec_undef_i),
  .dec_dslot_i (dec_dslot_i),
  .dec_pcw_i   (dec_pcw_i),
  .prev_done_i (prev_done_i),
  .por_rise    (por_rise),
  .mr_rise     (mr_rise),
  .ae_fire     (ae_fire),
  .start_o     (start_o),
  .type_o      (type_o)
);

// File: tb/tb_exc_src_detect.sv
module tb_exc_src_detect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_pin_ni = 1'b1, mrst_pin_ni = 1'b1;
  logic       wdt_ovf_i = 0, addr_err_i = 0, dec_valid_i = 0, dec_undef_i = 0;
  logic       dec_dslot_i = 0, dec_pcw_i = 0, trap_exec_i = 0, prev_done_i = 0;
  logic       irq_req_i = 0;
  logic       start_o;
  logic [2:0] type_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  exc_src_detect dut (.*);

  // {wdt, ae, valid, undef, dslot, pcw, trap, pdone, irq, exp_start, exp_type[2:0]}
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_0_0_0_0_0_0_0_0_000, // idle
    13'b1_0_0_0_0_0_0_0_0_1_000, // R1 watchdog
    13'b0_0_1_1_1_0_0_0_0_1_011, // R4 undef in slot
    13'b0_0_1_0_1_1_0_0_0_1_011, // R5 pc-write in slot
    13'b0_0_1_1_0_0_0_0_0_1_100, // R6 undef outside slot
    13'b0_0_0_1_1_1_0_0_0_0_000, // R6 flags ignored without valid
    13'b0_0_0_0_0_0_1_0_0_1_101, // R7 trap
    13'b0_0_0_0_0_0_0_0_1_1_110, // R8 interrupt
    13'b0_0_1_0_0_1_0_0_0_0_000, // R5 branch outside slot
    13'b0_1_1_0_0_0_0_0_0_0_000, // R3 detect
    13'b0_0_0_0_0_0_0_0_0_0_000, // R3 held, prev not done
    13'b0_0_0_0_0_0_0_1_0_1_010, // R3 start
    13'b0_1_1_1_1_0_0_0_0_1_011, // R9 slot fires, ae pending
    13'b0_0_0_0_0_0_1_1_0_1_010, // R9 ae beats trap
    13'b0_0_0_0_0_0_0_0_0_0_000, // R9 trap dropped
    13'b0_0_1_1_0_0_1_0_1_1_100, // R9 illegal beats trap/irq
    13'b1_1_1_0_0_0_0_0_0_1_000, // R9 watchdog wins, flushes ae
    13'b0_0_0_0_0_0_0_1_0_0_000, // R9 no ae after flush
    13'b0_1_1_0_0_0_0_1_0_0_000, // R3 same-cycle done does not start
    13'b0_0_0_0_0_0_0_1_0_1_010  // R3 start next
  };

  task automatic check(input logic s, input logic [2:0] t, input string req);
    n_chk++;
    if (start_o !== s || type_o !== t) begin
      n_fail++;
      $display("FAIL %s: start=%0b type=%0d expected start=%0b type=%0d",
               req, start_o, type_o, s, t);
    end
  endtask

  task automatic clr_in();
    {wdt_ovf_i, addr_err_i, dec_valid_i, dec_undef_i, dec_dslot_i,
     dec_pcw_i, trap_exec_i, prev_done_i, irq_req_i} = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1'b0, 3'd0, "R11 reset state");
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      check(1'b0, 3'd0, "R11 release with pins high");
    end

    for (int i = 0; i < NV; i++) begin
      {wdt_ovf_i, addr_err_i, dec_valid_i, dec_undef_i, dec_dslot_i,
       dec_pcw_i, trap_exec_i, prev_done_i, irq_req_i} = VEC[i][12:4];
      @(negedge clk_i);
      check(VEC[i][3], VEC[i][2:0], $sformatf("R1-group vector %0d", i));
    end
    clr_in();
    @(negedge clk_i);

    // R2/R11: manual pin held low gives nothing, rise gives one pulse on 3rd edge
    mrst_pin_ni = 1'b0;
    repeat (5) begin
      @(negedge clk_i);
      check(1'b0, 3'd0, "R11 pin held low");
    end
    mrst_pin_ni = 1'b1;
    @(negedge clk_i); check(1'b0, 3'd0, "R2 latency edge 1");
    @(negedge clk_i); check(1'b0, 3'd0, "R2 latency edge 2");
    @(negedge clk_i); check(1'b1, 3'd1, "R2 manual reset start");
    @(negedge clk_i); check(1'b0, 3'd0, "R10 single pulse");
    repeat (3) begin
      @(negedge clk_i);
      check(1'b0, 3'd0, "R11 pin held high");
    end

    // R1: primary pin rise
    por_pin_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    por_pin_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    check(1'b0, 3'd0, "R1 not before third edge");
    @(negedge clk_i); check(1'b1, 3'd0, "R1 power-on start");
    @(negedge clk_i); check(1'b0, 3'd0, "R10 single pulse after R1");

    // R9: both pins rise together, power-on wins
    por_pin_ni = 1'b0; mrst_pin_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    por_pin_ni = 1'b1; mrst_pin_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(1'b1, 3'd0, "R9 power-on beats manual");
    @(negedge clk_i); check(1'b0, 3'd0, "R9 manual dropped");

    // R9: manual reset flushes pending address error
    mrst_pin_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    addr_err_i = 1; dec_valid_i = 1; mrst_pin_ni = 1'b1;
    @(negedge clk_i); clr_in();
    @(negedge clk_i);
    @(negedge clk_i); check(1'b1, 3'd1, "R9 manual start");
    prev_done_i = 1;
    @(negedge clk_i); check(1'b0, 3'd0, "R9 ae flushed by manual reset");
    clr_in();

    // R11: async reset mid-operation clears outputs
    trap_exec_i = 1;
    @(negedge clk_i); clr_in();
    rst_ni = 1'b0;
    #1 check(1'b0, 3'd0, "R11 async reset clears");
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); check(1'b0, 3'd0, "R11 quiet after reset");

    done = 1;
    finish_run();
  end
endmodule